// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This unit serves loads and stores from a 16-bit core into a byte-addressed data space. Storage is split into two byte-wide halves that share one word index and have their own write strobes. The even half holds the byte at an address with bit 0 clear, and the odd half holds the byte with bit 0 set. Byte stores touch only the half chosen by address bit 0. Word stores touch both halves. Reads are registered, and load data appears one clock after the request.

The unit also returns the next value of a post-incremented pointer. It detects word accesses at odd addresses and reports them with a one-cycle trap pulse and a held copy of the faulting address. An odd word read still returns the containing word. An odd word write is dropped. A second output gives the value to write back into a working register. For byte loads this value either keeps the register's old upper byte or widens the byte with zeros or with its sign bit.

Only a window of `RAM_BYTES` bytes starting at `RAM_BASE` (default 0x0800 to 0x0BFF) is backed by storage. The register region below it, and everything above it, reads as zero and ignores writes. In short-address mode only the low 13 address bits are used, which reaches the low 8 KB.

Top module: `dmem_access_unit`

## Requirements
- R1: `ptr_next` equals `addr` + 1 when `is_byte` is 1 and `addr` + 2 when it is 0, with modulo 2^16 wrap. It is combinational.
- R2: A byte read returns the addressed byte on `rdata[7:0]` with `rdata[15:8]` = 0, one clock after `rd_en`. When address bit 0 is 0 the byte is bits 7:0 of the stored word, and when it is 1 the byte is bits 15:8.
- R3: A word read at an even address returns the stored word one clock after `rd_en`. The byte at the even address is in bits 7:0 and the byte at address+1 is in bits 15:8.
- R4: A byte write stores `wdata[7:0]` into the one half selected by address bit 0 and leaves the other half unchanged.
- R5: A word read or write at an odd address gives `addr_err` = 1 for exactly the next cycle, with `err_addr` set to that access's `addr`. Byte accesses and idle cycles give `addr_err` = 0. `err_addr` holds its value until the next fault.
- R6: A word read at an odd address still completes and returns the word at the address with bit 0 cleared.
- R7: A word write at an odd address changes no stored byte.
- R8: On a byte load with `ext_mode` 2'b00 (or 2'b11), `wb_data` = {`dst_old[15:8]` sampled with the request, loaded byte}.
- R9: On a byte load, `ext_mode` 2'b01 gives `wb_data` = {8'h00, byte} and 2'b10 gives the byte sign-extended to 16 bits. On a word load, `wb_data` equals the loaded word whatever `ext_mode` is.
- R10: Effective addresses outside [`RAM_BASE`, `RAM_BASE`+`RAM_BYTES`) read as zero, and writes to them change no stored byte.
- R11: With `near_mode` = 1 the effective address is {3'b000, `addr[12:0]`}. With `near_mode` = 0 all 16 bits are used.
- R12: After reset `rdata`, `wb_data`, `err_addr` and `addr_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Byte address (pointer value) |
| wdata | input | 16 | Store data; byte stores use bits 7:0 |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| rd_en | input | 1 | Load request |
| wr_en | input | 1 | Store request |
| near_mode | input | 1 | 1 = 13-bit short address |
| ext_mode | input | 2 | Byte-load widening: 00 keep upper, 01 zero, 10 sign, 11 keep |
| dst_old | input | 16 | Current value of the destination register |
| rdata | output | 16 | Raw load data path |
| wb_data | output | 16 | Value to write back to the destination register |
| ptr_next | output | 16 | Post-incremented pointer |
| addr_err | output | 1 | One-cycle misalignment trap pulse |
| err_addr | output | 16 | Address of the last faulting access |

## Verification
The assertions check on every cycle that an odd word store raises no lane strobe, that a byte access strobes at most one lane, and that the trap pulse and captured address follow a faulting access while byte and idle cycles raise none. They also check the zero upper byte of byte reads and the upper byte produced by keep and zero-extend loads. The stored contents can only be seen through later reads, so only the bench scenarios can show the following: which half a byte store changed, that a dropped odd store and a store outside the window left memory intact, that short-address mode aliased onto the window, and that an odd word read returned the containing word.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned DATA_W    = LANE_W * NUM_LANES;
  localparam int unsigned NEAR_W    = 13;

  typedef enum logic [1:0] {
    EXT_KEEP = 2'b00,
    EXT_ZERO = 2'b01,
    EXT_SIGN = 2'b10,
    EXT_RSVD = 2'b11
  } ext_mode_e;

endpackage

// File: rtl/dmem_addr_step.sv
module dmem_addr_step
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BASE  = 16'h0800,
  parameter int unsigned RAM_BYTES = 1024,
  localparam int unsigned IDX_W    = $clog2(RAM_BYTES) - 1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_byte,
  input  logic                 near_mode,
  input  logic                 wr_en,
  output logic [ADDR_W-1:0]    ptr_next,
  output logic [IDX_W-1:0]     word_idx,
  output logic                 in_win,
  output logic                 odd_byte,
  output logic                 misaligned,
  output logic [NUM_LANES-1:0] lane_we
);

  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0] SIZE_X = (ADDR_W+1)'(RAM_BYTES);

  logic [ADDR_W-1:0] eff;
  logic [ADDR_W:0]   off_x;

  always_comb begin
    if (near_mode) begin
      eff = {{(ADDR_W-NEAR_W){1'b0}}, addr[NEAR_W-1:0]};
    end else begin
      eff = addr;
    end
  end

  // Offset into the backed window; the extra top bit flags a negative offset.
  assign off_x    = {1'b0, eff} - BASE_X;
  assign in_win   = !off_x[ADDR_W] && (off_x < SIZE_X);
  assign word_idx = off_x[IDX_W:1];
  assign odd_byte = eff[0];

  assign misaligned = !is_byte && eff[0];
  assign ptr_next   = addr + (is_byte ? ADDR_W'(1) : ADDR_W'(2));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_we
    localparam logic LSEL = 1'(l);
    logic hit;
    assign hit        = is_byte ? (eff[0] == LSEL) : 1'b1;
    assign lane_we[l] = wr_en && in_win && !misaligned && hit;
  end

endmodule

// File: rtl/dmem_byte_lane.sv
module dmem_byte_lane #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd_q
);

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wd;
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (re) begin
      rd_d = mem[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/dmem_load_merge.sv
module dmem_load_merge
  import dmem_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        capture,
  input  logic                        is_byte,
  input  logic                        sel_hi,
  input  logic                        in_win,
  input  ext_mode_e                   ext_mode,
  input  logic [LANE_W-1:0]           dst_hi,
  input  logic [NUM_LANES*LANE_W-1:0] lane_data,
  output logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           wb_data
);

  logic              byte_q, byte_d;
  logic              hi_q, hi_d;
  logic              win_q, win_d;
  ext_mode_e         ext_q, ext_d;
  logic [LANE_W-1:0] dhi_q, dhi_d;

  always_comb begin
    byte_d = byte_q;
    hi_d   = hi_q;
    win_d  = win_q;
    ext_d  = ext_q;
    dhi_d  = dhi_q;
    if (capture) begin
      byte_d = is_byte;
      hi_d   = sel_hi;
      win_d  = in_win;
      ext_d  = ext_mode;
      dhi_d  = dst_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= 1'b0;
      hi_q   <= 1'b0;
      win_q  <= 1'b0;
      ext_q  <= EXT_KEEP;
      dhi_q  <= '0;
    end else begin
      byte_q <= byte_d;
      hi_q   <= hi_d;
      win_q  <= win_d;
      ext_q  <= ext_d;
      dhi_q  <= dhi_d;
    end
  end

  logic [DATA_W-1:0] word_v;
  logic [LANE_W-1:0] byte_v;

  assign word_v = win_q ? lane_data : '0;
  assign byte_v = hi_q ? word_v[2*LANE_W-1:LANE_W] : word_v[LANE_W-1:0];

  always_comb begin
    if (byte_q) begin
      rdata = {{LANE_W{1'b0}}, byte_v};
      unique case (ext_q)
        EXT_ZERO: wb_data = {{LANE_W{1'b0}}, byte_v};
        EXT_SIGN: wb_data = {{LANE_W{byte_v[LANE_W-1]}}, byte_v};
        default:  wb_data = {dhi_q, byte_v};
      endcase
    end else begin
      rdata   = word_v;
      wb_data = word_v;
    end
  end

endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
  import dmem_pkg::*;
#(
  parameter int unsigned RAM_BASE  = 16'h0800,
  parameter int unsigned RAM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  input  logic        is_byte,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        near_mode,
  input  logic [1:0]  ext_mode,
  input  logic [15:0] dst_old,
  output logic [15:0] rdata,
  output logic [15:0] wb_data,
  output logic [15:0] ptr_next,
  output logic        addr_err,
  output logic [15:0] err_addr
);

  localparam int unsigned ADDR_W = DATA_W;
  localparam int unsigned IDX_W  = $clog2(RAM_BYTES) - 1;

  // Reset: asserted at once, released through two flops.
  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  logic [IDX_W-1:0]     word_idx;
  logic                 in_win, odd_byte, misaligned;
  logic [NUM_LANES-1:0] lane_we;

  dmem_addr_step #(
    .ADDR_W   (ADDR_W),
    .RAM_BASE (RAM_BASE),
    .RAM_BYTES(RAM_BYTES)
  ) u_step (
    .addr      (addr),
    .is_byte   (is_byte),
    .near_mode (near_mode),
    .wr_en     (wr_en),
    .ptr_next  (ptr_next),
    .word_idx  (word_idx),
    .in_win    (in_win),
    .odd_byte  (odd_byte),
    .misaligned(misaligned),
    .lane_we   (lane_we)
  );

  logic [NUM_LANES-1:0][LANE_W-1:0] lane_rd;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] wd_l;
    assign wd_l = is_byte ? wdata[LANE_W-1:0] : wdata[l*LANE_W +: LANE_W];
    dmem_byte_lane #(
      .LANE_W(LANE_W),
      .IDX_W (IDX_W)
    ) u_lane (
      .clk  (clk),
      .rst_n(rst_q_n),
      .we   (lane_we[l]),
      .re   (rd_en),
      .idx  (word_idx),
      .wd   (wd_l),
      .rd_q (lane_rd[l])
    );
  end

  dmem_load_merge u_merge (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .capture  (rd_en),
    .is_byte  (is_byte),
    .sel_hi   (odd_byte),
    .in_win   (in_win),
    .ext_mode (ext_mode_e'(ext_mode)),
    .dst_hi   (dst_old[DATA_W-1:LANE_W]),
    .lane_data(lane_rd),
    .rdata    (rdata),
    .wb_data  (wb_data)
  );

  // Trap pulse and faulting-address capture.
  logic              err_d, err_q;
  logic [ADDR_W-1:0] eaddr_d, eaddr_q;
  logic              fault;

  assign fault = (rd_en || wr_en) && misaligned;

  always_comb begin
    err_d   = fault;
    eaddr_d = eaddr_q;
    if (fault) begin
      eaddr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      err_q   <= 1'b0;
      eaddr_q <= '0;
    end else begin
      err_q   <= err_d;
      eaddr_q <= eaddr_d;
    end
  end

  assign addr_err = err_q;
  assign err_addr = eaddr_q;

endmodule

// File: rtl/dmem_access_chk.sv
module dmem_access_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic [15:0] addr,
  input logic        is_byte,
  input logic        rd_en,
  input logic        wr_en,
  input logic [1:0]  ext_mode,
  input logic [15:0] dst_old,
  input logic [15:0] rdata,
  input logic [15:0] wb_data,
  input logic        addr_err,
  input logic [15:0] err_addr,
  input logic [1:0]  lane_we
);

  assert_odd_store_dropped_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && !is_byte && addr[0]) |-> (lane_we == 2'b00));

  assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    is_byte |-> ($countones(lane_we) <= 1));

  assert_trap_pulse_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((rd_en || wr_en) && !is_byte && addr[0]) |=> (addr_err && err_addr == $past(addr)));

  assert_byte_no_trap_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (is_byte || !(rd_en || wr_en)) |=> !addr_err);

  assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && is_byte) |=> (rdata[15:8] == 8'h00));

  assert_keep_upper_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && is_byte && ext_mode == 2'b00) |=> (wb_data[15:8] == $past(dst_old[15:8])));

  assert_zero_ext_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && is_byte && ext_mode == 2'b01) |=> (wb_data[15:8] == 8'h00));

endmodule

bind dmem_access_unit dmem_access_chk u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .addr    (addr),
  .is_byte (is_byte),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .ext_mode(ext_mode),
  .dst_old (dst_old),
  .rdata   (rdata),
  .wb_data (wb_data),
  .addr_err(addr_err),
  .err_addr(err_addr),
  .lane_we (lane_we)
);

// File: tb/dmem_access_unit_tb_top.sv
module dmem_access_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_LO = 16'h0800;
  localparam int WIN_HI = 16'h0C00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr, wdata, dst_old;
  logic        is_byte, rd_en, wr_en, near_mode;
  logic [1:0]  ext_mode;
  logic [15:0] rdata, wb_data, ptr_next, err_addr;
  logic        addr_err;

  dmem_access_unit dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .is_byte(is_byte),
    .rd_en(rd_en), .wr_en(wr_en), .near_mode(near_mode), .ext_mode(ext_mode),
    .dst_old(dst_old), .rdata(rdata), .wb_data(wb_data), .ptr_next(ptr_next),
    .addr_err(addr_err), .err_addr(err_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int          due;
    bit          chk_data;
    logic [15:0] e_rdata;
    logic [15:0] e_wb;
    bit          e_err;
    logic [15:0] e_eaddr;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  bit [7:0]    ref_mem [int];
  logic [15:0] last_eaddr = 16'h0000;

  task automatic check(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int eff_of(logic [15:0] a, bit near);
    return near ? int'(a[12:0]) : int'(a);
  endfunction

  function automatic bit in_win(int e);
    return (e >= WIN_LO) && (e < WIN_HI);
  endfunction

  function automatic logic [7:0] ref_rd(int e);
    if (in_win(e) && ref_mem.exists(e)) return ref_mem[e];
    return 8'h00;
  endfunction

  // Driver: applies one access at a falling edge and queues what should follow.
  task automatic access(bit rd, bit wr, bit byt, bit near, logic [15:0] a,
                        logic [15:0] wd, logic [1:0] ext, logic [15:0] dold, string req);
    int e;
    int wa;
    bit mis;
    logic [7:0]  b;
    logic [15:0] w;
    exp_t it;
    e   = eff_of(a, near);
    wa  = e & ~1;
    mis = !byt && a[0];
    b   = ref_rd(e);
    w   = {ref_rd(wa + 1), ref_rd(wa)};
    addr = a; wdata = wd; is_byte = byt; rd_en = rd; wr_en = wr;
    near_mode = near; ext_mode = ext; dst_old = dold;
    it.due      = cyc + 1;
    it.chk_data = rd;
    it.e_rdata  = byt ? {8'h00, b} : w;
    if (byt) begin
      case (ext)
        2'b01:   it.e_wb = {8'h00, b};
        2'b10:   it.e_wb = {{8{b[7]}}, b};
        default: it.e_wb = {dold[15:8], b};
      endcase
    end else begin
      it.e_wb = w;
    end
    if ((rd || wr) && mis) last_eaddr = a;
    it.e_err   = (rd || wr) && mis;
    it.e_eaddr = last_eaddr;
    it.req     = req;
    sb_q.push_back(it);
    if (wr && !mis && in_win(e)) begin
      ref_mem[e] = wd[7:0];
      if (!byt) ref_mem[e + 1] = wd[15:8];
    end
    #1;
    check(ptr_next == a + (byt ? 16'd1 : 16'd2), "R1", "ptr_next", ptr_next,
          a + (byt ? 16'd1 : 16'd2));
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle(string req);
    exp_t it;
    rd_en = 1'b0; wr_en = 1'b0;
    it.due = cyc + 1; it.chk_data = 0; it.e_rdata = '0; it.e_wb = '0;
    it.e_err = 0; it.e_eaddr = last_eaddr; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: pops items whose result cycle has come and compares them.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      if (it.chk_data) begin
        check(rdata == it.e_rdata, it.req, "rdata", rdata, it.e_rdata);
        check(wb_data == it.e_wb, it.req, "wb_data", wb_data, it.e_wb);
      end
      check(addr_err == it.e_err, "R5", "addr_err", 16'(addr_err), 16'(it.e_err));
      check(err_addr == it.e_eaddr, "R5", "err_addr", err_addr, it.e_eaddr);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; is_byte = 0; rd_en = 0; wr_en = 0;
    near_mode = 0; ext_mode = 2'b00; dst_old = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check(rdata == 16'h0, "R12", "rdata", rdata, 16'h0);
    check(wb_data == 16'h0, "R12", "wb_data", wb_data, 16'h0);
    check(addr_err == 1'b0, "R12", "addr_err", 16'(addr_err), 16'h0);
    check(err_addr == 16'h0, "R12", "err_addr", err_addr, 16'h0);

    // R3 word store and load
    access(0, 1, 0, 0, 16'h0800, 16'hBEEF, 2'b00, 16'h0, "R3");
    access(1, 0, 0, 0, 16'h0800, 16'h0, 2'b00, 16'h0, "R3");
    // R2 byte loads from both halves
    access(1, 0, 1, 0, 16'h0800, 16'h0, 2'b00, 16'h0, "R2");
    access(1, 0, 1, 0, 16'h0801, 16'h0, 2'b00, 16'h0, "R2");
    // R4 byte stores touch one half only
    access(0, 1, 1, 0, 16'h0801, 16'hFF5A, 2'b00, 16'h0, "R4");
    access(0, 1, 1, 0, 16'h0800, 16'h1234, 2'b00, 16'h0, "R4");
    access(1, 0, 0, 0, 16'h0800, 16'h0, 2'b00, 16'h0, "R4");
    // R8 merge keeps old upper byte
    access(1, 0, 1, 0, 16'h0801, 16'h0, 2'b00, 16'hC300, "R8");
    access(0, 1, 1, 0, 16'h0802, 16'h009C, 2'b00, 16'h0, "R4");
    access(1, 0, 1, 0, 16'h0802, 16'h0, 2'b11, 16'h1234, "R8");
    // R9 widening
    access(1, 0, 1, 0, 16'h0802, 16'h0, 2'b10, 16'h1234, "R9");
    access(1, 0, 1, 0, 16'h0802, 16'h0, 2'b01, 16'h1234, "R9");
    access(1, 0, 0, 0, 16'h0800, 16'h0, 2'b10, 16'h1234, "R9");
    // R6 odd word load completes and traps; R5 pulse ends
    access(0, 1, 0, 0, 16'h0802, 16'h7788, 2'b00, 16'h0, "R3");
    access(1, 0, 0, 0, 16'h0803, 16'h0, 2'b00, 16'h0, "R6");
    idle("R5");
    // R7 odd word store dropped
    access(0, 1, 0, 0, 16'h0804, 16'h2468, 2'b00, 16'h0, "R3");
    access(0, 1, 0, 0, 16'h0805, 16'h1111, 2'b00, 16'h0, "R7");
    access(1, 0, 0, 0, 16'h0804, 16'h0, 2'b00, 16'h0, "R7");
    access(1, 0, 1, 0, 16'h0805, 16'h0, 2'b00, 16'h0, "R5");
    // R10 outside the window
    access(0, 1, 0, 0, 16'h0400, 16'hAAAA, 2'b00, 16'h0, "R10");
    access(1, 0, 0, 0, 16'h0400, 16'h0, 2'b00, 16'h0, "R10");
    access(0, 1, 0, 0, 16'h0C00, 16'h5555, 2'b00, 16'h0, "R10");
    access(1, 0, 0, 0, 16'h0800, 16'h0, 2'b00, 16'h0, "R10");
    access(1, 0, 0, 0, 16'h0C00, 16'h0, 2'b00, 16'h0, "R10");
    access(1, 0, 1, 0, 16'h07FF, 16'h0, 2'b00, 16'h0, "R10");
    access(0, 1, 0, 0, 16'h0BFE, 16'hA55A, 2'b00, 16'h0, "R10");
    access(1, 0, 0, 0, 16'h0BFE, 16'h0, 2'b00, 16'h0, "R10");
    // R11 short addressing
    access(0, 1, 0, 1, 16'hE806, 16'h3C3C, 2'b00, 16'h0, "R11");
    access(1, 0, 0, 0, 16'h0806, 16'h0, 2'b00, 16'h0, "R11");
    access(1, 0, 0, 0, 16'hE806, 16'h0, 2'b00, 16'h0, "R11");
    access(1, 0, 1, 1, 16'h2807, 16'h0, 2'b00, 16'h0, "R11");
    // R1 pointer wrap
    access(1, 0, 0, 0, 16'hFFFE, 16'h0, 2'b00, 16'h0, "R1");
    access(1, 0, 1, 0, 16'hFFFF, 16'h0, 2'b00, 16'h0, "R1");
    // Sweep: byte stores, then word loads (R2, R3, R4)
    for (int i = 0; i < 16; i++)
      access(0, 1, 1, 0, 16'(16'h0900 + i), 16'(i * 17 + 3), 2'b00, 16'h0, "R4");
    for (int k = 0; k < 8; k++)
      access(1, 0, 0, 0, 16'(16'h0900 + 2 * k), 16'h0, 2'b00, 16'h0, "R3");
    for (int k = 0; k < 4; k++)
      access(1, 0, 1, 0, 16'(16'h0903 + 4 * k), 16'h0, 2'b10, 16'hEE00, "R2");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule